// File: doc/BRIEF.md
# Infrared Pulse-Width Qualifier with Echo Blanking

This block takes the output of an infrared receive comparator, working in the return-to-zero pulse-width scheme used by serial infrared links, and turns qualified pulses into a UART-style receive line. The comparator input is synchronized to a fixed reference clock. The width of each high pulse is then counted in reference cycles. A pulse is accepted only when its width falls inside a window. Both edges of the window are set by configuration: the lower edge is a fixed time, and the upper edge is either a fixed time or a fraction of the programmed bit period.

Each accepted pulse drives the receive line low for one bit period. A rejected pulse leaves the line high. When the local transmitter drives its LEDs, the receiver would see its own light. Echo blanking can hold the receive line idle while the LEDs are on, and for a guard time of 8 µs after they turn off.

The bit period is given in reference cycles on a plain input, so rates down to 1200 baud can be used. Configuration bits are captured into a register on a write strobe. They take defined values at reset. The block has no streaming data interface: its output is a line level, so no valid/ready handshake or back-pressure applies.

Top module: `ir_pulse_qualifier`

## Requirements
- R1: The comparator input passes through two synchronizer flops. The measured width of a pulse equals the number of reference-clock rising edges at which the input was high.
- R2: With the narrow-minimum bit clear, a pulse is accepted only if its width is at least TICKS_PER_US cycles (1 µs). One cycle less is rejected.
- R3: With the narrow-minimum bit set, the lower limit is TICKS_PER_US/2 cycles (0.5 µs), in both window modes.
- R4: In fixed mode (mode bit 0) with the wide bit clear, the upper limit is 5*TICKS_PER_US/2 cycles (2.5 µs), inclusive.
- R5: In fixed mode with the wide bit set, the upper limit is floor(9*bit_ticks/16), inclusive. The wide bit has no effect in proportional mode.
- R6: In proportional mode (mode bit 1), the upper limit is floor(3*bit_ticks/16), inclusive.
- R7: An accepted pulse drives rxd low for exactly bit_ticks cycles, starting within a few cycles of the pulse end. A rejected pulse leaves rxd high throughout.
- R8: With the blanking bit set, rxd is held high while led_on is high and for 8*TICKS_PER_US cycles after led_on falls. After that, a low period still in progress shows again.
- R9: With the blanking bit clear, led_on has no effect on rxd.
- R10: After reset, rxd is high and the configuration is: fixed mode, narrow-minimum 0, wide 1, blanking 0.
- R11: A bit period of 13334 cycles (1200 baud at a 16 MHz reference) is accepted and stretched correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed reference clock, TICKS_PER_US cycles per µs |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Asynchronous comparator output, high while light is detected |
| led_on | input | 1 | High while the local transmit LEDs are driven |
| bit_ticks | input | DIV_W | Bit period in reference cycles |
| cfg_we | input | 1 | Captures the four configuration bits below |
| cfg_mode | input | 1 | Window mode: 0 fixed, 1 proportional |
| cfg_thin | input | 1 | Narrow-minimum select |
| cfg_wide | input | 1 | Wide-maximum select (fixed mode only) |
| cfg_blank | input | 1 | Echo-blanking enable |
| rxd | output | 1 | Receive line to the UART, idle high |

## Verification
A wrong window limit shows up as a pulse of boundary width that is stretched when it should not be, or the reverse. This is visible on rxd about three cycles after the pulse ends. A fault in the stretch counter changes the length of the low period, which can be counted exactly against bit_ticks. A fault in the guard counter lets rxd fall early after the LEDs go off, or keeps it high well past the guard. So the bench samples across that window while a long low period is still in progress.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    WIN_FIXED = 1'b0,
    WIN_PROP  = 1'b1
  } win_mode_e;

  typedef struct packed {
    win_mode_e mode;
    logic      thin;
    logic      wide;
    logic      blank;
  } irq_cfg_t;

  localparam irq_cfg_t CFG_RESET = '{mode: WIN_FIXED, thin: 1'b0, wide: 1'b1, blank: 1'b0};
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_width_meas.sv
module irq_width_meas
  import irq_pkg::*;
#(
  parameter int TICKS_PER_US = 16,
  parameter int DIV_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  irq_cfg_t         cfg,
  input  logic [DIV_W-1:0] bit_ticks,
  output logic             accept
);
  localparam int PW       = DIV_W + 4;
  localparam int MIN_STD  = TICKS_PER_US;
  localparam int MIN_THIN = TICKS_PER_US / 2;
  localparam int FIX_MAX  = (5 * TICKS_PER_US) / 2;
  localparam logic [DIV_W-1:0] SAT = {DIV_W{1'b1}};

  logic             lvl_d;
  logic [DIV_W-1:0] wcnt;
  logic             pulse_end;
  logic [PW-1:0]    frac3, frac9;
  logic [PW-1:0]    min_lim, max_lim;
  logic             in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      wcnt  <= '0;
    end else begin
      lvl_d <= lvl;
      if (lvl) begin
        if (!lvl_d)          wcnt <= DIV_W'(1);
        else if (wcnt != SAT) wcnt <= wcnt + 1'b1;
      end
    end
  end

  assign pulse_end = lvl_d & ~lvl;

  always_comb begin
    frac3   = (PW'(bit_ticks) * PW'(3)) >> 4;
    frac9   = (PW'(bit_ticks) * PW'(9)) >> 4;
    min_lim = cfg.thin ? PW'(MIN_THIN) : PW'(MIN_STD);
    if (cfg.mode == WIN_PROP) max_lim = frac3;
    else if (cfg.wide)        max_lim = frac9;
    else                      max_lim = PW'(FIX_MAX);
    in_window = (PW'(wcnt) >= min_lim) && (PW'(wcnt) <= max_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accept <= 1'b0;
    else        accept <= pulse_end & in_window;
  end

  // R3
  thin_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($past(wcnt) >= DIV_W'(MIN_THIN)));

  // R2
  std_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !$past(cfg.thin)) |-> ($past(wcnt) >= DIV_W'(MIN_STD)));

  // R1
  end_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($past(lvl_d) && !$past(lvl)));
endmodule

// File: rtl/irq_stretch.sv
module irq_stretch #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [DIV_W-1:0] bit_ticks,
  output logic             low
);
  logic [DIV_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (accept)         remain <= bit_ticks;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign low = (remain != '0);

  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low) |-> $past(accept));
endmodule

// File: rtl/irq_blank.sv
module irq_blank #(
  parameter int GUARD = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic led_on,
  output logic blank
);
  localparam int GW = $clog2(GUARD + 1);

  logic [GW-1:0] guard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            guard <= '0;
    else if (led_on)       guard <= GW'(GUARD);
    else if (guard != '0)  guard <= guard - 1'b1;
  end

  assign blank = en & (led_on | (guard != '0));

  // R8
  guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(led_on) && !led_on) |-> blank);
endmodule

// File: rtl/ir_pulse_qualifier.sv
module ir_pulse_qualifier
  import irq_pkg::*;
#(
  parameter int TICKS_PER_US = 16,
  parameter int DIV_W        = 16,
  parameter int GUARD_US     = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_in,
  input  logic             led_on,
  input  logic [DIV_W-1:0] bit_ticks,
  input  logic             cfg_we,
  input  logic             cfg_mode,
  input  logic             cfg_thin,
  input  logic             cfg_wide,
  input  logic             cfg_blank,
  output logic             rxd
);
  localparam int GUARD = GUARD_US * TICKS_PER_US;

  irq_cfg_t cfg_q;
  logic     ir_sync;
  logic     accept;
  logic     low;
  logic     blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else if (cfg_we) begin
      cfg_q.mode  <= win_mode_e'(cfg_mode);
      cfg_q.thin  <= cfg_thin;
      cfg_q.wide  <= cfg_wide;
      cfg_q.blank <= cfg_blank;
    end
  end

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ir_in), .q_sync(ir_sync)
  );

  irq_width_meas #(.TICKS_PER_US(TICKS_PER_US), .DIV_W(DIV_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .lvl(ir_sync), .cfg(cfg_q),
    .bit_ticks(bit_ticks), .accept(accept)
  );

  irq_stretch #(.DIV_W(DIV_W)) u_stretch (
    .clk(clk), .rst_n(rst_n), .accept(accept), .bit_ticks(bit_ticks), .low(low)
  );

  irq_blank #(.GUARD(GUARD)) u_blank (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.blank), .led_on(led_on), .blank(blank)
  );

  assign rxd = blank | ~low;

  // R7
  accept_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bit_ticks != '0) |=> (!rxd || blank));

  // R9
  no_blank_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.blank && low) |-> !rxd);
endmodule

// File: tb/ir_pulse_qualifier_tb.sv
`timescale 1ns/1ps
module ir_pulse_qualifier_tb;
  localparam int TPU   = 16;
  localparam int GUARD = 8 * TPU;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        led_on = 1'b0;
  logic [15:0] bit_ticks = 16'd160;
  logic        cfg_we = 1'b0, cfg_mode = 1'b0, cfg_thin = 1'b0, cfg_wide = 1'b1, cfg_blank = 1'b0;
  logic        rxd;

  int n_chk = 0;
  int n_fail = 0;
  int c_mode = 0, c_thin = 0, c_wide = 1;

  always #2.5 clk = ~clk;

  ir_pulse_qualifier u_dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .led_on(led_on), .bit_ticks(bit_ticks),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_thin(cfg_thin), .cfg_wide(cfg_wide),
    .cfg_blank(cfg_blank), .rxd(rxd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_accept(input int w, input int m, input int th, input int wd, input int b);
    int lo, hi;
    lo = th ? TPU / 2 : TPU;
    if (m) hi = (3 * b) / 16;
    else if (wd) hi = (9 * b) / 16;
    else hi = (5 * TPU) / 2;
    return (w >= lo && w <= hi) ? 1 : 0;
  endfunction

  task automatic set_cfg(input int m, input int th, input int wd, input int bl);
    @(negedge clk);
    cfg_mode = m[0]; cfg_thin = th[0]; cfg_wide = wd[0]; cfg_blank = bl[0];
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    c_mode = m; c_thin = th; c_wide = wd;
  endtask

  task automatic send(input int w, output int lows);
    int b;
    b = int'(bit_ticks);
    lows = 0;
    @(negedge clk);
    ir_in = 1'b1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (!rxd) lows++;
    end
    ir_in = 1'b0;
    for (int i = 0; i < b + 24; i++) begin
      @(negedge clk);
      if (!rxd) lows++;
    end
  endtask

  task automatic pulse_chk(input int w, input string req);
    int lows, e;
    e = exp_accept(w, c_mode, c_thin, c_wide, int'(bit_ticks)) ? int'(bit_ticks) : 0;
    send(w, lows);
    chk(lows == e, req, lows, e);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic blank_case(input int bl, input string req);
    int lows;
    bit_ticks = 16'd1000;
    set_cfg(0, 0, 1, bl);
    @(negedge clk); ir_in = 1'b1;
    repeat (20) @(negedge clk);
    ir_in = 1'b0;
    repeat (10) @(negedge clk);
    chk(rxd == 1'b0, req, rxd, 0);
    led_on = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(rxd == (bl ? 1'b1 : 1'b0), req, rxd, bl);
    end
    led_on = 1'b0;
    for (int i = 0; i < GUARD - 8; i++) begin
      @(negedge clk);
      if (i % 20 == 0) chk(rxd == (bl ? 1'b1 : 1'b0), req, rxd, bl);
    end
    repeat (30) @(negedge clk);
    chk(rxd == 1'b0, req, rxd, 0);
    repeat (1100) @(negedge clk);
    lows = 0;
    chk(rxd == 1'b1, req, rxd, 1);
  endtask

  initial begin
    int w, b;
    void'($urandom(32'd7351));
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(rxd == 1'b1, "R10", rxd, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rxd == 1'b1, "R10", rxd, 1);
    // R10 defaults: fixed, thin 0, wide 1, blank 0 (no cfg write yet)
    pulse_chk(90, "R10_R5 wide default");
    pulse_chk(91, "R5 above 9/16");
    pulse_chk(12, "R10 thin default");
    pulse_chk(16, "R2 min edge");
    pulse_chk(15, "R2 below min");
    pulse_chk(1, "R1 single cycle");
    set_cfg(0, 1, 1, 0);
    pulse_chk(8, "R3 thin edge");
    pulse_chk(7, "R3 below thin");
    set_cfg(0, 0, 0, 0);
    pulse_chk(40, "R4 fixed max");
    pulse_chk(41, "R4 above fixed max");
    set_cfg(1, 0, 0, 0);
    pulse_chk(30, "R6 prop max");
    pulse_chk(31, "R6 above prop max");
    set_cfg(1, 1, 1, 0);
    pulse_chk(31, "R5 wide no effect in prop");
    pulse_chk(8, "R3 thin in prop");
    blank_case(1, "R8");
    blank_case(0, "R9");
    // R11 1200 baud
    bit_ticks = 16'd13334;
    set_cfg(1, 0, 0, 0);
    pulse_chk(2000, "R11 long bit");
    pulse_chk(2501, "R11 above 3/16");
    // random mix R7
    for (int t = 0; t < 90; t++) begin
      case ($urandom % 3)
        0: b = 160;
        1: b = 320;
        default: b = 480;
      endcase
      bit_ticks = 16'(b);
      set_cfg(int'($urandom % 2), int'($urandom % 2), int'($urandom % 2), 0);
      w = 1 + int'($urandom % ((b * 10) / 16));
      pulse_chk(w, "R7 random");
    end
    finish_run();
  end
endmodule